// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller for an external dual-slope integrating converter. It steps a two-bit phase-select output through four phases in a fixed order: zeroing the offset, integrating the unknown input for a set time, discharging the integrator against the reference for a measured time, and clearing the integrator. The analog integrator, the reference switches and the comparator stay outside the block. The block only drives the phase lines and watches the comparator.

The discharge phase has no fixed length. The block counts clocks until the comparator output is seen falling, and a hard cap ends the phase if no fall arrives. The input polarity is taken from the comparator level at the close of the integrate phase. When the discharge ends, the count, the polarity and an overrange flag are latched and a one-cycle done strobe is raised. A start pulse begins one conversion from idle. With continuous mode held high, the block chains conversions back to back. All phase lengths are parameters. The defaults suit a 1.8432 MHz clock: 123,093 clocks of zeroing, 123,093 clocks of integration, a cap of 246,185 counts and 1,843 clocks of integrator clearing.

Top module: `dual_slope_seq`

## Requirements
- R1: The phases follow each other as zeroing, integrate, discharge, clear, and {phase_a,phase_b} reads 2'b00 in zeroing, 2'b10 in integrate, 2'b11 in discharge and 2'b01 in clear. Idle also reads 2'b00.
- R2: Zeroing lasts exactly AZ_CLKS clocks, integrate lasts INT_CLKS clocks and clear lasts IZ_CLKS clocks.
- R3: comp_in passes through a two-flop synchronizer. Discharge ends on the first clock at which the synchronized comparator shows a high-to-low step. result_count then equals the number of clocks spent in discharge, that clock included. A fall applied to comp_in during discharge clock j therefore gives a count of j+2.
- R4: If no fall has been seen by the DEINT_MAX-th discharge clock, discharge ends there with result_count = DEINT_MAX and result_over = 1. A fall seen on that same clock gives result_over = 0.
- R5: result_neg is 1 when the synchronized comparator is low on the last integrate clock, and 0 when it is high.
- R6: done is high for exactly one clock, the first clear clock. result_count, result_neg and result_over change only at the edge that raises done, and they hold their values otherwise.
- R7: Comparator falls during zeroing, integrate and clear do not end any phase and do not alter any phase length or result.
- R8: A start seen in idle enters zeroing on the next clock. A start seen during a conversion has no effect.
- R9: If cont_mode is high on the last clear clock, zeroing follows at once. Otherwise the block returns to idle and stays there until a start arrives.
- R10: While rst_n is low, the block is idle with phase 2'b00, done is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a conversion when the block is idle |
| cont_mode | input | 1 | Repeat conversions without a new start |
| comp_in | input | 1 | Asynchronous comparator output |
| phase_a | output | 1 | Phase select, high bit |
| phase_b | output | 1 | Phase select, low bit |
| done | output | 1 | One-cycle strobe when results update |
| result_count | output | CW | Discharge length in clocks |
| result_neg | output | 1 | Input polarity, 1 for negative |
| result_over | output | 1 | Discharge was ended by the cap |

## Verification
The assertions assume that the phase-length parameters are at least one clock, and that INT_CLKS is at least three so the synchronizer has settled before polarity is sampled. They also assume the reset is held for at least one clock edge. The stimulus changes comp_in and start only on falling clock edges. It holds the comparator at its polarity level through most of integrate. For negative inputs it raises the comparator in the first discharge clock and drops it no earlier than the second, so that exactly one clean fall reaches the edge detector. Comparator glitching is confined to the phases where it must be ignored.

// File: rtl/dual_slope_seq.sv
module dual_slope_seq #(
  parameter int AZ_CLKS   = 123093,
  parameter int INT_CLKS  = 123093,
  parameter int IZ_CLKS   = 1843,
  parameter int DEINT_MAX = 246185,
  localparam int PH_A     = (AZ_CLKS > INT_CLKS) ? AZ_CLKS : INT_CLKS,
  localparam int PH_B     = (PH_A > IZ_CLKS) ? PH_A : IZ_CLKS,
  localparam int PH_MAX   = (PH_B > DEINT_MAX) ? PH_B : DEINT_MAX,
  localparam int CW       = $clog2(PH_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cont_mode,
  input  logic          comp_in,
  output logic          phase_a,
  output logic          phase_b,
  output logic          done,
  output logic [CW-1:0] result_count,
  output logic          result_neg,
  output logic          result_over
);

  typedef enum logic [2:0] {S_IDLE, S_AZ, S_INT, S_DEI, S_IZ} st_t;

  st_t           st;
  logic [CW-1:0] tick;
  logic          s1, s2, s3;
  logic          sign_q;

  wire           fall    = s3 & ~s2;
  wire [CW-1:0]  nxt     = tick + 1'b1;
  wire           last_az = (tick == CW'(AZ_CLKS - 1));
  wire           last_in = (tick == CW'(INT_CLKS - 1));
  wire           last_iz = (tick == CW'(IZ_CLKS - 1));
  wire           at_cap  = (nxt == CW'(DEINT_MAX));

  assign phase_a = (st == S_INT) || (st == S_DEI);
  assign phase_b = (st == S_DEI) || (st == S_IZ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      tick         <= '0;
      s1           <= 1'b0;
      s2           <= 1'b0;
      s3           <= 1'b0;
      sign_q       <= 1'b0;
      done         <= 1'b0;
      result_count <= '0;
      result_neg   <= 1'b0;
      result_over  <= 1'b0;
    end else begin
      s1   <= comp_in;
      s2   <= s1;
      s3   <= s2;
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          tick <= '0;
          if (start) st <= S_AZ;
        end
        S_AZ: begin
          if (last_az) begin
            st   <= S_INT;
            tick <= '0;
          end else tick <= nxt;
        end
        S_INT: begin
          if (last_in) begin
            st     <= S_DEI;
            tick   <= '0;
            sign_q <= ~s2;
          end else tick <= nxt;
        end
        S_DEI: begin
          if (fall || at_cap) begin
            st           <= S_IZ;
            tick         <= '0;
            done         <= 1'b1;
            result_count <= nxt;
            result_neg   <= sign_q;
            result_over  <= ~fall;
          end else tick <= nxt;
        end
        S_IZ: begin
          if (last_iz) begin
            st   <= cont_mode ? S_AZ : S_IDLE;
            tick <= '0;
          end else tick <= nxt;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_int_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ({phase_a, phase_b} == 2'b10) |=> ({phase_a, phase_b} == 2'b10 || {phase_a, phase_b} == 2'b11));

  p_dei_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ({phase_a, phase_b} == 2'b11) |=> ({phase_a, phase_b} == 2'b11 || {phase_a, phase_b} == 2'b01));

  p_iz_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ({phase_a, phase_b} == 2'b01) |=> ({phase_a, phase_b} == 2'b01 || {phase_a, phase_b} == 2'b00));

  p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEI) |-> (tick < CW'(DEINT_MAX)));

  p_over_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result_over) |-> (result_count == CW'(DEINT_MAX)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({phase_a, phase_b} == 2'b01));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result_count) && $stable(result_neg) && $stable(result_over)));

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (st == S_AZ));

endmodule

// File: tb/test_dual_slope_seq.sv
`timescale 1ns/1ps
module test_dual_slope_seq;
  localparam int AZ = 5, INT = 6, IZ = 3, DMAX = 20;
  localparam int CW = $clog2(DMAX + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cont_mode = 1'b0, comp_in = 1'b1;
  logic phase_a, phase_b, done, result_neg, result_over;
  logic [CW-1:0] result_count;
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 1'b0;

  dual_slope_seq #(.AZ_CLKS(AZ), .INT_CLKS(INT), .IZ_CLKS(IZ), .DEINT_MAX(DMAX)) i_dual_slope_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_mode(cont_mode), .comp_in(comp_in),
    .phase_a(phase_a), .phase_b(phase_b), .done(done), .result_count(result_count),
    .result_neg(result_neg), .result_over(result_over));

  always #2.5 clk = ~clk;

  // vector: {glitch, polarity level, drop clock (0 = never)}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 1'b1, 8'd1},  {1'b0, 1'b1, 8'd7},  {1'b0, 1'b0, 8'd4},  {1'b0, 1'b1, 8'd18},
    {1'b0, 1'b1, 8'd19}, {1'b0, 1'b1, 8'd0},  {1'b1, 1'b0, 8'd2},  {1'b1, 1'b1, 8'd10}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ph();
    return {phase_a, phase_b};
  endfunction

  // called at the first negedge of zeroing; returns at the first negedge after clear
  task automatic conv(input logic glitch, input logic lvl, input int drop);
    int n;
    int expc = (drop == 0 || drop + 2 > DMAX) ? DMAX : drop + 2;
    bit expo = (drop == 0 || drop + 2 > DMAX);
    n = 0;
    while (ph() == 2'b00 && n < 50) begin
      if (glitch) comp_in = n[0];   // R7 falls in zeroing
      chk(!done, "R6 done low in zeroing", done, 0);
      n++; @(negedge clk);
    end
    chk(n == AZ, "R2 zeroing length", n, AZ);
    n = 0;
    while (ph() == 2'b10 && n < 50) begin
      comp_in = lvl;
      start = (n == 2);             // R8 start ignored while busy
      n++; @(negedge clk);
    end
    start = 1'b0;
    chk(n == INT, "R2 integrate length (R8 mid-run start)", n, INT);
    chk(ph() == 2'b11, "R1 discharge follows integrate", ph(), 3);
    n = 0;
    while (ph() == 2'b11 && n < 100) begin
      n++;
      if (!lvl && n == 1) comp_in = 1'b1;
      if (n == drop) comp_in = 1'b0;
      chk(!done, "R6 done low in discharge", done, 0);
      @(negedge clk);
    end
    chk(n == expc, "R3 discharge length", n, expc);
    chk(ph() == 2'b01, "R1 clear follows discharge", ph(), 1);
    chk(done, "R6 done on first clear clock", done, 1);
    chk(result_count == CW'(expc), "R3 R4 result_count", result_count, expc);
    chk(result_over == expo, "R4 result_over", result_over, expo);
    chk(result_neg == ~lvl, "R5 result_neg", result_neg, ~lvl);
    n = 0;
    while (ph() == 2'b01 && n < 50) begin
      if (n > 0) chk(!done, "R6 done single cycle", done, 0);
      if (glitch) comp_in = n[0];   // R7 falls in clear
      n++; @(negedge clk);
    end
    comp_in = 1'b1;
    chk(n == IZ, "R2 clear length", n, IZ);
    chk(result_count == CW'(expc), "R6 result held", result_count, expc);
  endtask

  task automatic kick();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk(ph() == 2'b00 && !done, "R10 reset phase and done", {ph(), done}, 0);
    chk(result_count == 0 && !result_neg && !result_over, "R10 reset results", result_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 8; v++) begin
      kick();
      conv(VEC[v][9], VEC[v][8], int'(VEC[v][7:0]));
      for (int k = 0; k < 4; k++) begin
        chk(ph() == 2'b00 && !done, "R9 stays idle without cont_mode", ph(), 0);
        @(negedge clk);
      end
    end
    cont_mode = 1'b1;
    kick();
    conv(1'b0, 1'b1, 5);
    cont_mode = 1'b0;
    conv(1'b0, 1'b0, 6);            // R9 entered without a start
    chk(ph() == 2'b00, "R9 idle after continuous run", ph(), 0);
    kick();
    while (ph() != 2'b11) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ph() == 2'b00 && !done, "R10 reset mid conversion", ph(), 0);
    chk(result_count == 0, "R10 results cleared", result_count, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ph() == 2'b00, "R8 no start after reset", ph(), 0);
    kick();
    chk(ph() == 2'b00, "R8 start enters zeroing", ph(), 0);
    conv(1'b0, 1'b1, 3);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !finished) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule